// File: doc/BRIEF.md
# Six-Switch Hall Commutator with Split Chopping

This block turns a single chopping signal and three Hall position lines into the six gate commands of a three-phase bridge for a brushless permanent-magnet machine. Each gate is on for two of the six Hall sectors. In the first of those sectors it is held steadily on, and in the second it follows the chopping signal. The stress of switching is therefore shared evenly across the bridge, and in each sector only one device of the conducting pair switches.

A mode input selects the motoring equation set or the regenerating equation set. The regenerating set uses the complemented Hall terms, which moves the gate pattern by half an electrical cycle. A mode request is applied only when the synchronised Hall code changes, so a gate never changes part-way through a sector. A blocking input forces every gate off, for example during start-up or after an overcurrent trip. The Hall codes 000 and 111 cannot occur on a healthy sensor. Either code turns the bridge off and raises a fault flag. The equations assume one fixed phase rotation. Dead time and the generation of the chopping signal are handled elsewhere.

Top module: `bldc_gate_mux`

## Requirements
- R1: While `rst` is high at a clock edge, `gate_o` becomes 000000 and `fault_o` becomes 0 after that edge. The reset is synchronous and active-high.
- R2: `hall_i` passes through SYNC_STAGES flops (default 2) and then one output register. A Hall change therefore shows on the outputs SYNC_STAGES+1 edges later. `pwm_i` and `block_i` act after one edge.
- R3: `hall_i` bit 2 is HA, bit 1 is HB and bit 0 is HC. `gate_o` bit k drives switch T(k+1). In motoring mode with `pwm_i` low, the single steady switch is set by the code: 101→T1, 100→T2, 110→T3, 010→T4, 011→T5, 001→T6.
- R4: When `pwm_i` is high, the switch whose index is one lower than the steady switch (T6 below T1) is also turned on. When `pwm_i` is low, only the steady switch is on.
- R5: In regenerating mode (`gen_mode_i`=1), the steady switch for code c is the motoring steady switch for the bitwise complement of c: 010→T1, 011→T2, 001→T3, 101→T4, 100→T5, 110→T6.
- R6: The mode in use changes only on a clock where the synchronised Hall code differs from the code of the previous clock. It takes the `gen_mode_i` value sampled on that clock. While the Hall code holds, toggling `gen_mode_i` leaves `gate_o` unchanged. After reset the mode in use is motoring.
- R7: When `block_i` is high at an edge, `gate_o` is 000000 after that edge, whatever the other inputs are.
- R8: A synchronised Hall code of 000 or 111 drives `gate_o` to 000000 and `fault_o` to 1 one edge later. Any other code drives `fault_o` to 0.
- R9: At most two gates are on at any time, and two gates are on only when they are adjacent in the cyclic order T1..T6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | Common chopping signal |
| hall_i | input | 3 | Asynchronous Hall lines, bit 2 = HA, bit 0 = HC |
| gen_mode_i | input | 1 | 1 selects the regenerating equation set |
| block_i | input | 1 | 1 forces all gates off |
| gate_o | output | 6 | Registered gate commands, bit k = T(k+1) |
| fault_o | output | 1 | Registered illegal-Hall flag |

## Verification
The hardest case to reach is a mode request that arrives part-way through a sector. The gates must keep their pattern, and the new set must take over exactly at the next synchronised Hall edge. The bench holds a legal Hall code and toggles `gen_mode_i` for many cycles while the chopping signal is frozen. It then moves the Hall code and checks that the new equation set takes effect SYNC_STAGES+1 edges after the move. Random phases also change Hall codes, the chopping signal and the mode together, so that edges and mode requests land in the same cycle.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int HALL_W = 3;
  localparam int NUM_SW = 6;

  typedef logic [HALL_W-1:0] hall_t;
  typedef logic [NUM_SW-1:0] gate_t;

  // Hall bit pair used by the steady term of switch k (pattern repeats every 3)
  function automatic int pair_hi(input int k);
    return (k % 3 == 1) ? 1 : 2;
  endfunction

  function automatic int pair_lo(input int k);
    return (k % 3 == 2) ? 1 : 0;
  endfunction

  // even-indexed switches use true Hall terms, odd ones inverted terms
  function automatic bit pair_pos(input int k);
    return (k % 2) == 0;
  endfunction
endpackage

// File: rtl/bldc_hall_sync.sv
module bldc_hall_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/bldc_mode_track.sv
module bldc_mode_track
  import bldc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  hall_t hall_s,
  input  logic  mode_req,
  output logic  mode_sel,
  output logic  illegal
);
  hall_t hall_prev;
  logic  mode_q;
  logic  hall_edge;

  assign hall_edge = (hall_s != hall_prev);
  assign mode_sel  = hall_edge ? mode_req : mode_q;
  assign illegal   = (hall_s == '0) || (hall_s == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hall_prev <= '0;
      mode_q    <= 1'b0;
    end else begin
      hall_prev <= hall_s;
      mode_q    <= mode_sel;
    end
  end
endmodule

// File: rtl/bldc_gate_eq.sv
module bldc_gate_eq
  import bldc_pkg::*;
(
  input  hall_t hall_s,
  input  logic  gen_mode,
  input  logic  pwm,
  output gate_t gate_c
);
  hall_t h;
  gate_t steady;

  // regenerating set = motoring set on complemented Hall lines
  assign h = gen_mode ? ~hall_s : hall_s;

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    localparam int HI = pair_hi(k);
    localparam int LO = pair_lo(k);
    localparam int NX = (k + 1) % NUM_SW;
    if (pair_pos(k)) begin : g_pos
      assign steady[k] = h[HI] & h[LO];
    end else begin : g_neg
      assign steady[k] = ~h[HI] & ~h[LO];
    end
    // conduction window is this switch's sector and its successor's;
    // inside it the PWM-or-steady equation applies
    assign gate_c[k] = steady[k] | (pwm & steady[NX]);
  end
endmodule

// File: rtl/bldc_gate_mux.sv
module bldc_gate_mux
  import bldc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_i,
  input  logic [2:0] hall_i,
  input  logic       gen_mode_i,
  input  logic       block_i,
  output logic [5:0] gate_o,
  output logic       fault_o
);
  hall_t hall_s;
  logic  mode_sel;
  logic  illegal;
  gate_t gate_c;

  bldc_hall_sync #(.STAGES(SYNC_STAGES), .WIDTH(HALL_W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (hall_i),
    .sync_o  (hall_s)
  );

  bldc_mode_track u_mode (
    .clk      (clk),
    .rst      (rst),
    .hall_s   (hall_s),
    .mode_req (gen_mode_i),
    .mode_sel (mode_sel),
    .illegal  (illegal)
  );

  bldc_gate_eq u_eq (
    .hall_s   (hall_s),
    .gen_mode (mode_sel),
    .pwm      (pwm_i),
    .gate_c   (gate_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      gate_o  <= (block_i || illegal) ? '0 : gate_c;
      fault_o <= illegal;
    end
  end
endmodule

// File: rtl/bldc_gate_mux_chk.sv
module bldc_gate_mux_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwm_i,
  input logic       block_i,
  input logic [2:0] hall_s,
  input logic [5:0] gate_o,
  input logic       fault_o
);
  logic [2:0] hall_d;
  logic [1:0] armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hall_d <= '0;
      armed  <= '0;
    end else begin
      hall_d <= hall_s;
      if (armed != 2'd2) armed <= armed + 2'd1;
    end
  end

  // R9: never more than two switches on
  p_max_two_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_o) <= 2);

  // R7: blocking clears all gates
  p_block_off_r7: assert property (@(posedge clk) disable iff (rst)
    block_i |=> (gate_o == 6'b0));

  // R8: illegal code turns the bridge off and flags
  p_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    (hall_s == 3'b000 || hall_s == 3'b111) |=> (gate_o == 6'b0 && fault_o));

  // R8: legal code clears the flag
  p_legal_r8: assert property (@(posedge clk) disable iff (rst)
    (hall_s != 3'b000 && hall_s != 3'b111) |=> !fault_o);

  // R4: with chopping low exactly one switch conducts
  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    (!pwm_i && !block_i && hall_s != 3'b000 && hall_s != 3'b111)
      |=> ($countones(gate_o) == 1));

  // R6: no gate change inside a sector when nothing else moves
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed == 2'd2 && hall_s == hall_d && pwm_i == $past(pwm_i)
      && !block_i && !$past(block_i)) |=> $stable(gate_o));
endmodule

bind bldc_gate_mux bldc_gate_mux_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwm_i   (pwm_i),
  .block_i (block_i),
  .hall_s  (hall_s),
  .gate_o  (gate_o),
  .fault_o (fault_o)
);

// File: tb/sim_bldc_gate_mux.sv
module sim_bldc_gate_mux;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_i = 1'b0;
  logic [2:0] hall_i = 3'b000;
  logic       gen_mode_i = 1'b0;
  logic       block_i = 1'b0;
  logic [5:0] gate_o;
  logic       fault_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  bldc_gate_mux #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .pwm_i(pwm_i), .hall_i(hall_i),
    .gen_mode_i(gen_mode_i), .block_i(block_i),
    .gate_o(gate_o), .fault_o(fault_o)
  );

  // steady switch per code, motoring set (one-hot, bit k = T(k+1))
  function automatic logic [5:0] steady_motor(input logic [2:0] c);
    case (c)
      3'b101:  return 6'b000001;
      3'b100:  return 6'b000010;
      3'b110:  return 6'b000100;
      3'b010:  return 6'b001000;
      3'b011:  return 6'b010000;
      3'b001:  return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] expect_gates(input logic [2:0] c, input logic gen,
                                              input logic pwm);
    logic [5:0] st;
    st = gen ? steady_motor(~c) : steady_motor(c);
    return pwm ? (st | {st[0], st[5:1]}) : st;
  endfunction

  // behavioural reference
  logic [2:0] hq[$];
  logic [2:0] m_last;
  logic       m_mode;
  logic [5:0] exp_gate;
  logic       exp_fault;

  initial begin
    for (int i = 0; i < SYNC; i++) hq.push_back(3'b000);
    m_last = 3'b000; m_mode = 1'b0; exp_gate = '0; exp_fault = 1'b0;
  end

  always @(posedge clk) begin
    logic [2:0] cur;
    logic       use_gen;
    if (rst) begin
      hq.delete();
      for (int i = 0; i < SYNC; i++) hq.push_back(3'b000);
      m_last = 3'b000; m_mode = 1'b0; exp_gate = '0; exp_fault = 1'b0;
    end else begin
      cur = hq[SYNC-1];
      use_gen = (cur != m_last) ? gen_mode_i : m_mode;
      exp_fault = (cur == 3'b000 || cur == 3'b111);
      exp_gate = (block_i || exp_fault) ? 6'b0 : expect_gates(cur, use_gen, pwm_i);
      m_mode = use_gen;
      m_last = cur;
      void'(hq.pop_back());
      hq.push_front(hall_i);
    end
  end

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, {fault_o, gate_o}, {exp_fault, exp_gate});
      checks++;
      if ($countones(gate_o) > 2 ||
          ($countones(gate_o) == 2 && gate_o != 6'b100001 &&
           ((gate_o & (gate_o << 1)) == 6'b0))) begin
        errors++;
        $display("FAIL R9: got %b expected adjacent pair at most", gate_o);
      end
    end
  end

  task automatic drive(input logic [2:0] h, input logic p, input logic g,
                       input logic b, input int n);
    @(negedge clk);
    hall_i = h; pwm_i = p; gen_mode_i = g; block_i = b;
    repeat (n - 1) @(negedge clk);
  endtask

  localparam logic [2:0] SEQ [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check("R1", {fault_o, gate_o}, 7'b0);
    rst = 1'b0;

    // R3: motoring sectors, chopping low
    cur_req = "R3";
    for (int i = 0; i < 6; i++) drive(SEQ[i], 1'b0, 1'b0, 1'b0, 6);
    drive(3'b100, 1'b0, 1'b0, 1'b0, 6);
    check("R3", {fault_o, gate_o}, 7'b0000010);

    // R4: chopping high adds the preceding switch
    cur_req = "R4";
    for (int i = 0; i < 6; i++) drive(SEQ[i], 1'b1, 1'b0, 1'b0, 6);
    drive(3'b101, 1'b1, 1'b0, 1'b0, 6);
    check("R4", {fault_o, gate_o}, 7'b0100001);

    // R2: Hall latency SYNC+1, chopping latency 1
    cur_req = "R2";
    drive(3'b110, 1'b0, 1'b0, 1'b0, 1);
    repeat (SYNC) @(negedge clk);
    check("R2", {1'b0, gate_o}, {1'b0, 6'b000001});
    @(negedge clk);
    check("R2", {1'b0, gate_o}, {1'b0, 6'b000100});
    pwm_i = 1'b1;
    @(negedge clk);
    check("R2", {1'b0, gate_o}, {1'b0, 6'b000110});

    // R5: regenerating sectors
    cur_req = "R5";
    for (int i = 0; i < 6; i++) drive(SEQ[i], i[0], 1'b1, 1'b0, 6);
    drive(3'b010, 1'b0, 1'b1, 1'b0, 6);
    check("R5", {fault_o, gate_o}, 7'b0000001);

    // R6: mode toggles inside a sector have no effect
    cur_req = "R6";
    drive(3'b100, 1'b0, 1'b0, 1'b0, 6);
    check("R6", {fault_o, gate_o}, 7'b0000010);
    for (int i = 0; i < 10; i++) begin
      drive(3'b100, 1'b0, ~i[0], 1'b0, 1);
      check("R6", {fault_o, gate_o}, 7'b0000010);
    end
    drive(3'b100, 1'b0, 1'b1, 1'b0, 3);
    check("R6", {fault_o, gate_o}, 7'b0000010);
    drive(3'b110, 1'b0, 1'b1, 1'b0, SYNC + 2);
    check("R6", {fault_o, gate_o}, 7'b0100000);
    drive(3'b110, 1'b0, 1'b0, 1'b0, 4);
    check("R6", {fault_o, gate_o}, 7'b0100000);

    // R7: blocking
    cur_req = "R7";
    drive(3'b110, 1'b1, 1'b0, 1'b1, 3);
    check("R7", {fault_o, gate_o}, 7'b0);
    drive(3'b110, 1'b1, 1'b0, 1'b0, 2);

    // R8: illegal codes and recovery
    cur_req = "R8";
    drive(3'b111, 1'b1, 1'b0, 1'b0, 6);
    check("R8", {fault_o, gate_o}, 7'b1000000);
    drive(3'b000, 1'b0, 1'b1, 1'b0, 6);
    check("R8", {fault_o, gate_o}, 7'b1000000);
    drive(3'b011, 1'b0, 1'b0, 1'b0, 6);
    check("R8", {fault_o, gate_o}, 7'b0010000);

    // R9: random mixing of all inputs
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive((r < 80) ? SEQ[$urandom_range(0, 5)] : 3'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            (r > 95), $urandom_range(1, 6));
    end

    cur_req = "R1";
    drive(3'b101, 1'b1, 1'b0, 1'b0, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {fault_o, gate_o}, 7'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule